// File: doc/BRIEF.md
# Recovered-Clock Frequency Lock Monitor

This block checks whether a recovered line clock runs at the same frequency as an independent local reference clock. The reference is nominally 34.368 MHz, within ±100 ppm. The monitor counts recovered-clock cycles in a free-running Gray-coded counter. It carries that count into the reference domain through a short synchronizer chain. At the end of every fixed measurement window of reference cycles, it compares the number of recovered cycles that elapsed in the window with the window length. A difference beyond a tolerance, about 0.5 % by default, marks the window as out of lock.

The block drives two outputs in the reference domain. The loss-of-lock alarm goes high on any out-of-lock window. It stays high until lock is regained, which takes a set number of consecutive in-tolerance windows. Once raised, it stays high for a minimum number of reference cycles, however short the frequency error was. While the alarm is high, the block sends a one-cycle reacquire request to the loop at each judged window end. This request tells the loop to search again for frequency and phase.

No data stream passes through the block, so it has no valid/ready interface and no back-pressure. All pins are plain control and status levels.

Top module: `freq_lock_monitor`

## Requirements
- R1: While the reference reset is low, and directly after it is released, `lol_alarm` is 1 and `reacq_req` is 0.
- R2: A window is `WIN_CYCLES` reference cycles long, and windows follow each other without gaps from reset release. The first window after reset is used only to prime the count snapshot and is not judged. With a nominal clock, the alarm is therefore still high after the second window ends.
- R3: A window in which the recovered count differs from `WIN_CYCLES` by more than `TOL_COUNTS` raises `lol_alarm` one reference cycle after that window ends. This holds whether the recovered clock is fast or slow.
- R4: `lol_alarm` falls only after `LOCK_WINDOWS` (default 2) consecutive judged windows fall within tolerance. A recovered clock within tolerance, fast or slow, leaves the alarm low in steady state.
- R5: Once `lol_alarm` rises (or leaves reset), it stays high for at least `MIN_ALARM_CYCLES` reference cycles (default 32), even if lock returns sooner.
- R6: `reacq_req` is a one-cycle pulse. It occurs exactly once at the end of each judged window after which the alarm is high, and never while the alarm is low. A rising edge of the alarm is always accompanied by a pulse.
- R7: The recovered-clock count crosses into the reference domain as a Gray code through `SYNC_STAGES` flops. The count is only compared as a difference between consecutive snapshots, so a synchronizer offset of one count does not cause an out-of-lock window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Independent reference clock |
| ref_rst_n | input | 1 | Active-low asynchronous reset, reference domain |
| rec_clk | input | 1 | Recovered clock under test |
| rec_rst_n | input | 1 | Active-low asynchronous reset, recovered domain |
| lol_alarm | output | 1 | Loss-of-lock alarm, reference domain |
| reacq_req | output | 1 | One-cycle reacquire request, reference domain |

## Verification
The recovered clock is run at a nominal rate and at offsets inside and outside the tolerance band, on both the fast and the slow side. This separates the sign handling of the difference from the magnitude compare. Offsets of about 0.4 % and 0.8 % sit near the threshold and show that the single-count synchronizer error does not move the decision. A one-window frequency burst followed by a return to nominal shows the minimum-width stretching apart from the two-window lock rule. The start-up sequence shows the unjudged priming window, because the alarm must outlast the second window end. Counting request pulses over a fixed span of windows checks the one-per-window rate when out of lock and silence when locked.

// File: rtl/flm_pkg.sv
package flm_pkg;
  typedef struct packed {
    logic valid;
    logic good;
  } verdict_t;
endpackage

// File: rtl/flm_rec_counter.sv
module flm_rec_counter #(
  parameter int CW = 13
) (
  input  logic          rec_clk,
  input  logic          rec_rst_n,
  output logic [CW-1:0] gray_o
);
  logic [CW-1:0] bin_q;
  logic [CW-1:0] bin_d;

  assign bin_d = bin_q + 1'b1;

  always_ff @(posedge rec_clk or negedge rec_rst_n) begin
    if (!rec_rst_n) begin
      bin_q  <= '0;
      gray_o <= '0;
    end else begin
      bin_q  <= bin_d;
      gray_o <= bin_d ^ (bin_d >> 1);
    end
  end
endmodule

// File: rtl/flm_gray_sync.sv
module flm_gray_sync #(
  parameter int CW     = 13,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] gray_i,
  output logic [CW-1:0] bin_o
);
  logic [CW-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= gray_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  always_comb begin
    bin_o[CW-1] = stage_q[STAGES-1][CW-1];
    for (int i = CW - 2; i >= 0; i--) begin
      bin_o[i] = bin_o[i+1] ^ stage_q[STAGES-1][i];
    end
  end
endmodule

// File: rtl/flm_window_judge.sv
module flm_window_judge
  import flm_pkg::*;
#(
  parameter int WIN = 2048,
  parameter int TOL = 10,
  parameter int CW  = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt_bin,
  output verdict_t      verdict_o
);
  localparam int WCW = (WIN > 2) ? $clog2(WIN) : 1;
  localparam logic [WCW-1:0] LAST  = WCW'(WIN - 1);
  localparam logic [CW-1:0]  WIN_C = CW'(WIN);
  localparam logic [CW-1:0]  TOL_C = CW'(TOL);

  logic [WCW-1:0] tick_q;
  logic           win_end;
  logic [CW-1:0]  snap_q;
  logic           primed_q;
  logic [CW-1:0]  delta;
  logic [CW-1:0]  err;
  logic           in_tol;

  assign win_end = (tick_q == LAST);
  assign delta   = cnt_bin - snap_q;
  assign err     = (delta >= WIN_C) ? (delta - WIN_C) : (WIN_C - delta);
  assign in_tol  = (err <= TOL_C);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q    <= '0;
      snap_q    <= '0;
      primed_q  <= 1'b0;
      verdict_o <= '0;
    end else begin
      tick_q          <= win_end ? '0 : tick_q + 1'b1;
      verdict_o.valid <= win_end && primed_q;
      verdict_o.good  <= win_end ? in_tol : verdict_o.good;
      if (win_end) begin
        snap_q   <= cnt_bin;
        primed_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/flm_alarm_ctrl.sv
module flm_alarm_ctrl
  import flm_pkg::*;
#(
  parameter int MIN_ALARM = 32,
  parameter int LOCK_WINS = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  verdict_t verdict_i,
  output logic     alarm_o,
  output logic     reacq_o
);
  localparam int HW = $clog2(MIN_ALARM + 1);
  localparam int SW = $clog2(LOCK_WINS + 1);
  localparam logic [HW-1:0] HOLD_INIT = HW'(MIN_ALARM - 1);
  localparam logic [SW-1:0] STREAK_MAX = SW'(LOCK_WINS);

  logic [HW-1:0] hold_q, hold_d;
  logic [SW-1:0] streak_q, streak_d;
  logic          alarm_d;

  always_comb begin
    streak_d = streak_q;
    alarm_d  = alarm_o;
    hold_d   = (alarm_o && hold_q != '0) ? hold_q - 1'b1 : hold_q;
    if (verdict_i.valid) begin
      if (verdict_i.good) streak_d = (streak_q == STREAK_MAX) ? streak_q : streak_q + 1'b1;
      else                streak_d = '0;
    end
    if (verdict_i.valid && !verdict_i.good) begin
      alarm_d = 1'b1;
      hold_d  = HOLD_INIT;
    end else if (alarm_o && hold_q == '0 && streak_d == STREAK_MAX) begin
      alarm_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm_o  <= 1'b1;
      reacq_o  <= 1'b0;
      hold_q   <= HOLD_INIT;
      streak_q <= '0;
    end else begin
      alarm_o  <= alarm_d;
      reacq_o  <= verdict_i.valid && alarm_d;
      hold_q   <= hold_d;
      streak_q <= streak_d;
    end
  end
endmodule

// File: rtl/freq_lock_monitor.sv
module freq_lock_monitor
  import flm_pkg::*;
#(
  parameter int WIN_CYCLES       = 2048,
  parameter int TOL_COUNTS       = 10,
  parameter int MIN_ALARM_CYCLES = 32,
  parameter int LOCK_WINDOWS     = 2,
  parameter int SYNC_STAGES      = 2
) (
  input  logic ref_clk,
  input  logic ref_rst_n,
  input  logic rec_clk,
  input  logic rec_rst_n,
  output logic lol_alarm,
  output logic reacq_req
);
  localparam int CW = $clog2(WIN_CYCLES) + 2;

  logic [CW-1:0] rec_gray;
  logic [CW-1:0] ref_bin;
  verdict_t      verdict;

  flm_rec_counter #(.CW(CW)) u_rec_cnt (
    .rec_clk   (rec_clk),
    .rec_rst_n (rec_rst_n),
    .gray_o    (rec_gray)
  );

  flm_gray_sync #(.CW(CW), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (ref_clk),
    .rst_n  (ref_rst_n),
    .gray_i (rec_gray),
    .bin_o  (ref_bin)
  );

  flm_window_judge #(.WIN(WIN_CYCLES), .TOL(TOL_COUNTS), .CW(CW)) u_judge (
    .clk       (ref_clk),
    .rst_n     (ref_rst_n),
    .cnt_bin   (ref_bin),
    .verdict_o (verdict)
  );

  flm_alarm_ctrl #(.MIN_ALARM(MIN_ALARM_CYCLES), .LOCK_WINS(LOCK_WINDOWS)) u_alarm (
    .clk       (ref_clk),
    .rst_n     (ref_rst_n),
    .verdict_i (verdict),
    .alarm_o   (lol_alarm),
    .reacq_o   (reacq_req)
  );
endmodule

// File: rtl/flm_checker.sv
module flm_checker #(
  parameter int MIN_ALARM = 32
) (
  input logic clk,
  input logic rst_n,
  input logic alarm,
  input logic reacq
);
  int hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hi_cnt <= 0;
    else if (alarm) hi_cnt <= (hi_cnt < MIN_ALARM) ? hi_cnt + 1 : hi_cnt;
    else            hi_cnt <= 0;
  end

  a_r5_min_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(alarm) |-> hi_cnt >= MIN_ALARM);

  a_r6_req_needs_alarm: assert property (@(posedge clk) disable iff (!rst_n)
    reacq |-> alarm);

  a_r6_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    reacq |=> !reacq);

  a_r3_rise_with_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm) |-> reacq);

  a_r4_quiet_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(alarm) |-> !reacq);
endmodule

bind freq_lock_monitor flm_checker #(.MIN_ALARM(MIN_ALARM_CYCLES)) u_chk (
  .clk   (ref_clk),
  .rst_n (ref_rst_n),
  .alarm (lol_alarm),
  .reacq (reacq_req)
);

// File: tb/tb_freq_lock_monitor.sv
module tb_freq_lock_monitor;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int WIN  = 400;
  localparam int TOL  = 2;
  localparam int MINW = 1000;
  localparam int NV   = 7;
  // recovered half period in ps (reference half period is 2500 ps) and expected lock
  localparam int VEC_HALF [NV] = '{2500, 2475, 2490, 2525, 2510, 2480, 2520};
  localparam bit VEC_LOCK [NV] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0};

  logic ref_clk = 1'b0;
  logic rec_clk = 1'b0;
  logic rst_n   = 1'b0;
  logic lol_alarm, reacq_req;
  realtime rec_half = 2.5ns;
  int k = 0;
  int pulses = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  freq_lock_monitor #(
    .WIN_CYCLES(WIN), .TOL_COUNTS(TOL), .MIN_ALARM_CYCLES(MINW),
    .LOCK_WINDOWS(2), .SYNC_STAGES(2)
  ) dut (
    .ref_clk(ref_clk), .ref_rst_n(rst_n), .rec_clk(rec_clk), .rec_rst_n(rst_n),
    .lol_alarm(lol_alarm), .reacq_req(reacq_req)
  );

  always #2.5ns ref_clk = ~ref_clk;
  always #(rec_half) rec_clk = ~rec_clk;

  always @(posedge ref_clk) if (rst_n) k <= k + 1;
  always @(negedge ref_clk) if (rst_n && reacq_req) pulses <= pulses + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at k=%0d: actual %0d expected %0d", req, k, act, exp);
    end
  endtask

  task automatic wait_k(input int target);
    while (k < target) @(negedge ref_clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #1ms;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      finish_run();
    end
  end

  initial begin
    int k0, p0, rise;
    repeat (4) @(negedge ref_clk);
    check(lol_alarm === 1'b1, "R1 alarm in reset", int'(lol_alarm), 1);
    check(reacq_req === 1'b0, "R1 req in reset", int'(reacq_req), 0);
    rst_n = 1'b1;
    @(negedge ref_clk);
    check(lol_alarm === 1'b1, "R1 alarm after release", int'(lol_alarm), 1);

    // start-up: window 1 primes, window 2 judged, window 3 locks
    wait_k(2 * WIN + 10);
    check(lol_alarm === 1'b1, "R2 priming window not judged", int'(lol_alarm), 1);
    wait_k(3 * WIN + 10);
    check(lol_alarm === 1'b0, "R4 lock after two good windows", int'(lol_alarm), 0);
    check(pulses == 1, "R6 one request during start-up", pulses, 1);

    // vector table: R3 out of tolerance, R4 in tolerance, R7 either direction
    for (int i = 0; i < NV; i++) begin
      rec_half = VEC_HALF[i] * 1ps;
      k0 = k;
      wait_k(k0 + 5 * WIN);
      check(lol_alarm === !VEC_LOCK[i], VEC_LOCK[i] ? "R4 steady in-tolerance" : "R3 steady out-of-tolerance",
            int'(lol_alarm), int'(!VEC_LOCK[i]));
      p0 = pulses;
      k0 = k;
      wait_k(k0 + 4 * WIN);
      check(pulses - p0 == (VEC_LOCK[i] ? 0 : 4), "R6 request rate R7",
            pulses - p0, VEC_LOCK[i] ? 0 : 4);
    end

    // minimum width: one bad window, then nominal again
    rec_half = 2.5ns;
    wait_k(k + 5 * WIN);
    check(lol_alarm === 1'b0, "R4 relocked before burst", int'(lol_alarm), 0);
    k0 = ((k / WIN) + 1) * WIN;
    wait_k(k0 + 5);
    rec_half = 2.4ns;
    wait_k(k0 + WIN - 5);
    rec_half = 2.5ns;
    rise = k0 + WIN + 1;
    wait_k(rise + 9);
    check(lol_alarm === 1'b1, "R3 burst raises alarm", int'(lol_alarm), 1);
    wait_k(rise + 900);
    check(lol_alarm === 1'b1, "R5 alarm held past relock", int'(lol_alarm), 1);
    wait_k(rise + 1010);
    check(lol_alarm === 1'b0, "R5 alarm clears after hold", int'(lol_alarm), 0);

    done = 1'b1;
    finish_run();
  end
endmodule